// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block holds a small set of page translations and looks them up in one cycle. A translation is keyed by a virtual page number and an address-space identifier. Each stored entry carries a physical frame number, the identifier it belongs to, a shared-mapping flag, a read-enable mask and a write-enable mask with one bit per privilege mode, a trap-on-read flag and a trap-on-write flag. A lookup finds an entry when the page number matches and the entry is shared or belongs to the requesting identifier. The lookup is combinational and returns the slot number together with the fields of the entry.

New translations come in through an insert port. The slot is chosen by a rotating next-slot pointer, and whatever occupied that slot is discarded. Three invalidation commands maintain the contents. One empties the whole buffer. One drops every private, non-shared mapping, for use on a context switch. One drops the mappings of a single page under the current identifier. Depth and field widths are parameters; typical depths are 48 for instruction fetch and 64 for data.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup hits (lkHit=1) only on an entry that is valid, whose stored page number equals lkVpn, and that either has its shared flag set or has a stored identifier equal to lkAsn.
- R2: When several entries hit, the outputs come from the lowest-numbered of them, and lkSlot gives that slot number.
- R3: An insert (insValid=1) writes the entry at the slot held by the next-slot pointer and overwrites any valid entry there. The stored page number is insVa[VA_W-1:OFS_W]. The entry is valid and visible to lookups from the cycle after the insert.
- R4: Every insert advances the next-slot pointer by one. From slot DEPTH-1 it wraps to slot 0.
- R5: cmdFlushAll invalidates every entry and returns the next-slot pointer to slot 0.
- R6: cmdFlushProc invalidates every entry whose shared flag is clear and leaves shared entries valid.
- R7: cmdFlushAddr invalidates every entry that the lookup rule of R1 would match for flVpn and flAsn, and no other entry.
- R8: When an invalidation command and an insert arrive in the same cycle, the invalidation is applied first and the insert afterwards. The new entry therefore survives, and after cmdFlushAll it lands in slot 0. Commands issued together take effect as their union.
- R9: After reset no entry is valid and the next-slot pointer is at slot 0.
- R10: Lookup outputs follow lkVpn and lkAsn in the same cycle. On a miss, lkSlot and all entry fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkVpn | input | VPN_W | Page number to look up |
| lkAsn | input | ASN_W | Current address-space identifier |
| lkHit | output | 1 | A matching entry exists |
| lkSlot | output | PTR_W | Slot of the returned entry |
| lkPfn | output | PFN_W | Frame number of the returned entry |
| lkAsnOut | output | ASN_W | Stored identifier of the returned entry |
| lkGlobal | output | 1 | Shared flag of the returned entry |
| lkRdMask | output | MODE_N | Per-mode read enables |
| lkWrMask | output | MODE_N | Per-mode write enables |
| lkTrapRd | output | 1 | Trap-on-read flag |
| lkTrapWr | output | 1 | Trap-on-write flag |
| insValid | input | 1 | Insert strobe |
| insVa | input | VA_W | Virtual address of the new entry |
| insPfn | input | PFN_W | Frame number of the new entry |
| insAsn | input | ASN_W | Identifier of the new entry |
| insGlobal | input | 1 | Shared flag of the new entry |
| insRdMask | input | MODE_N | Read enables of the new entry |
| insWrMask | input | MODE_N | Write enables of the new entry |
| insTrapRd | input | 1 | Trap-on-read of the new entry |
| insTrapWr | input | 1 | Trap-on-write of the new entry |
| cmdFlushAll | input | 1 | Invalidate everything |
| cmdFlushProc | input | 1 | Invalidate non-shared entries |
| cmdFlushAddr | input | 1 | Invalidate one page's matches |
| flVpn | input | VPN_W | Page number for cmdFlushAddr |
| flAsn | input | ASN_W | Identifier for cmdFlushAddr |

## Verification
Directed sequences first fill the buffer past its depth. This separates a correct wrap of the pointer from an off-by-one, because the oldest page must miss and the newest must sit in slot 0. Pairs of entries with the same page number, one private and one shared, show whether matches are prioritised by slot and whether the identifier test is bypassed for shared entries. Each invalidation command is then issued, alone and together with an insert, and shared and private entries are probed afterwards to tell the three commands apart. A seeded random mix of inserts and commands over a small pool of page numbers and identifiers follows. That mix produces frequent aliasing and duplicates, and every probe is compared against a reference model kept in the bench.

// File: rtl/xlat_buffer_pkg.sv
package xlat_buffer_pkg;
  typedef struct packed {
    logic clrAll;
    logic clrProc;
    logic clrAddr;
    logic wrEntry;
  } xbStrobe_t;
endpackage

// File: rtl/xlat_buffer_ctrl.sv
module xlat_buffer_ctrl
  import xlat_buffer_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             cmdFlushAll,
  input  logic             cmdFlushProc,
  input  logic             cmdFlushAddr,
  output xbStrobe_t        strobe,
  output logic [PTR_W-1:0] wrSlot,
  output logic [PTR_W-1:0] ptrQ
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] basePtr;

  // an invalidate-all rewinds before the insert of the same cycle picks its slot
  assign basePtr = cmdFlushAll ? '0 : ptrQ;
  assign wrSlot  = basePtr;

  always_comb begin
    strobe.clrAll  = cmdFlushAll;
    strobe.clrProc = cmdFlushProc;
    strobe.clrAddr = cmdFlushAddr;
    strobe.wrEntry = insValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (insValid) begin
      ptrQ <= (basePtr == LAST) ? '0 : basePtr + 1'b1;
    end else begin
      ptrQ <= basePtr;
    end
  end
endmodule

// File: rtl/xlat_buffer_store.sv
module xlat_buffer_store
  import xlat_buffer_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int VPN_W  = 30,
  parameter int PFN_W  = 28,
  parameter int ASN_W  = 8,
  parameter int MODE_N = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xbStrobe_t                     strobe,
  input  logic [PTR_W-1:0]              wrSlot,
  input  logic [VPN_W-1:0]              wrVpn,
  input  logic [PFN_W-1:0]              wrPfn,
  input  logic [ASN_W-1:0]              wrAsn,
  input  logic                          wrGlobal,
  input  logic [MODE_N-1:0]             wrRdMask,
  input  logic [MODE_N-1:0]             wrWrMask,
  input  logic                          wrTrapRd,
  input  logic                          wrTrapWr,
  input  logic [VPN_W-1:0]              flVpn,
  input  logic [ASN_W-1:0]              flAsn,
  output logic [DEPTH-1:0]              vldQ,
  output logic [DEPTH-1:0]              glbQ,
  output logic [DEPTH-1:0][VPN_W-1:0]   tagQ,
  output logic [DEPTH-1:0][PFN_W-1:0]   pfnQ,
  output logic [DEPTH-1:0][ASN_W-1:0]   asnQ,
  output logic [DEPTH-1:0][MODE_N-1:0]  rdMaskQ,
  output logic [DEPTH-1:0][MODE_N-1:0]  wrMaskQ,
  output logic [DEPTH-1:0]              trapRdQ,
  output logic [DEPTH-1:0]              trapWrQ
);
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic kill;
    logic sel;

    assign sel  = strobe.wrEntry && (wrSlot == PTR_W'(g));
    assign kill = strobe.clrAll
                | (strobe.clrProc & ~glbQ[g])
                | (strobe.clrAddr & (tagQ[g] == flVpn) & (glbQ[g] | (asnQ[g] == flAsn)));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vldQ[g] <= 1'b0;
      end else if (sel) begin
        vldQ[g] <= 1'b1;
      end else if (kill) begin
        vldQ[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tagQ[g]    <= wrVpn;
        pfnQ[g]    <= wrPfn;
        asnQ[g]    <= wrAsn;
        glbQ[g]    <= wrGlobal;
        rdMaskQ[g] <= wrRdMask;
        wrMaskQ[g] <= wrWrMask;
        trapRdQ[g] <= wrTrapRd;
        trapWrQ[g] <= wrTrapWr;
      end
    end
  end
endmodule

// File: rtl/xlat_buffer_match.sv
module xlat_buffer_match #(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            vldQ,
  input  logic [DEPTH-1:0]            glbQ,
  input  logic [DEPTH-1:0][VPN_W-1:0] tagQ,
  input  logic [DEPTH-1:0][ASN_W-1:0] asnQ,
  input  logic [VPN_W-1:0]            lkVpn,
  input  logic [ASN_W-1:0]            lkAsn,
  output logic                        hit,
  output logic [PTR_W-1:0]            hitSlot
);
  logic [DEPTH-1:0] cand;

  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign cand[g] = vldQ[g] & (tagQ[g] == lkVpn) & (glbQ[g] | (asnQ[g] == lkAsn));
  end

  // scan downward so the lowest matching slot is the last one written
  always_comb begin
    hit     = 1'b0;
    hitSlot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hitSlot = PTR_W'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_buffer_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int VPN_W  = 30,
  parameter int OFS_W  = 13,
  parameter int PFN_W  = 28,
  parameter int ASN_W  = 8,
  parameter int MODE_N = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int VA_W  = VPN_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASN_W-1:0]  lkAsn,
  output logic              lkHit,
  output logic [PTR_W-1:0]  lkSlot,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [ASN_W-1:0]  lkAsnOut,
  output logic              lkGlobal,
  output logic [MODE_N-1:0] lkRdMask,
  output logic [MODE_N-1:0] lkWrMask,
  output logic              lkTrapRd,
  output logic              lkTrapWr,
  input  logic              insValid,
  input  logic [VA_W-1:0]   insVa,
  input  logic [PFN_W-1:0]  insPfn,
  input  logic [ASN_W-1:0]  insAsn,
  input  logic              insGlobal,
  input  logic [MODE_N-1:0] insRdMask,
  input  logic [MODE_N-1:0] insWrMask,
  input  logic              insTrapRd,
  input  logic              insTrapWr,
  input  logic              cmdFlushAll,
  input  logic              cmdFlushProc,
  input  logic              cmdFlushAddr,
  input  logic [VPN_W-1:0]  flVpn,
  input  logic [ASN_W-1:0]  flAsn
);
  xbStrobe_t                    strobe;
  logic [PTR_W-1:0]             wrSlot;
  logic [PTR_W-1:0]             ptrQ;
  logic [DEPTH-1:0]             vldQ;
  logic [DEPTH-1:0]             glbQ;
  logic [DEPTH-1:0][VPN_W-1:0]  tagQ;
  logic [DEPTH-1:0][PFN_W-1:0]  pfnQ;
  logic [DEPTH-1:0][ASN_W-1:0]  asnQ;
  logic [DEPTH-1:0][MODE_N-1:0] rdMaskQ;
  logic [DEPTH-1:0][MODE_N-1:0] wrMaskQ;
  logic [DEPTH-1:0]             trapRdQ;
  logic [DEPTH-1:0]             trapWrQ;
  logic                         hit;
  logic [PTR_W-1:0]             hitSlot;

  xlat_buffer_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid),
    .cmdFlushAll(cmdFlushAll), .cmdFlushProc(cmdFlushProc), .cmdFlushAddr(cmdFlushAddr),
    .strobe(strobe), .wrSlot(wrSlot), .ptrQ(ptrQ)
  );

  xlat_buffer_store #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASN_W(ASN_W), .MODE_N(MODE_N)
  ) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSlot(wrSlot),
    .wrVpn(insVa[VA_W-1:OFS_W]), .wrPfn(insPfn), .wrAsn(insAsn), .wrGlobal(insGlobal),
    .wrRdMask(insRdMask), .wrWrMask(insWrMask), .wrTrapRd(insTrapRd), .wrTrapWr(insTrapWr),
    .flVpn(flVpn), .flAsn(flAsn),
    .vldQ(vldQ), .glbQ(glbQ), .tagQ(tagQ), .pfnQ(pfnQ), .asnQ(asnQ),
    .rdMaskQ(rdMaskQ), .wrMaskQ(wrMaskQ), .trapRdQ(trapRdQ), .trapWrQ(trapWrQ)
  );

  xlat_buffer_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) i_match (
    .vldQ(vldQ), .glbQ(glbQ), .tagQ(tagQ), .asnQ(asnQ),
    .lkVpn(lkVpn), .lkAsn(lkAsn), .hit(hit), .hitSlot(hitSlot)
  );

  always_comb begin
    lkHit    = hit;
    lkSlot   = hit ? hitSlot : '0;
    lkPfn    = hit ? pfnQ[hitSlot] : '0;
    lkAsnOut = hit ? asnQ[hitSlot] : '0;
    lkGlobal = hit & glbQ[hitSlot];
    lkRdMask = hit ? rdMaskQ[hitSlot] : '0;
    lkWrMask = hit ? wrMaskQ[hitSlot] : '0;
    lkTrapRd = hit & trapRdQ[hitSlot];
    lkTrapWr = hit & trapWrQ[hitSlot];
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int OFS_W = 13,
  parameter int ASN_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int VA_W  = VPN_W + OFS_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             insValid,
  input logic [VA_W-1:0]  insVa,
  input logic [ASN_W-1:0] insAsn,
  input logic             cmdFlushAll,
  input logic             cmdFlushProc,
  input logic [VPN_W-1:0] lkVpn,
  input logic [ASN_W-1:0] lkAsn,
  input logic             lkHit,
  input logic             lkGlobal,
  input logic [ASN_W-1:0] lkAsnOut,
  input logic [PTR_W-1:0] ptrQ,
  input logic [DEPTH-1:0] vldQ,
  input logic [DEPTH-1:0] glbQ
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // R1
  hit_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkGlobal || (lkAsnOut == lkAsn)));

  // R3
  insert_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    insValid |=> (!((lkVpn == $past(insVa[VA_W-1:OFS_W])) && (lkAsn == $past(insAsn))) || lkHit));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !cmdFlushAll && ptrQ == LAST) |=> (ptrQ == '0));

  // R5
  flush_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFlushAll && !insValid) |=> (vldQ == '0 && ptrQ == '0 && !lkHit));

  // R6
  flush_proc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFlushProc && !insValid) |=> ((vldQ & ~glbQ) == '0));

  // R9
  reset_chk: assert property (@(posedge clk)
    !rstN |=> (vldQ == '0 && ptrQ == '0));
endmodule

bind xlat_buffer xlat_buffer_chk #(
  .DEPTH(DEPTH), .VPN_W(VPN_W), .OFS_W(OFS_W), .ASN_W(ASN_W)
) i_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .insVa(insVa), .insAsn(insAsn),
  .cmdFlushAll(cmdFlushAll), .cmdFlushProc(cmdFlushProc),
  .lkVpn(lkVpn), .lkAsn(lkAsn), .lkHit(lkHit), .lkGlobal(lkGlobal), .lkAsnOut(lkAsnOut),
  .ptrQ(ptrQ), .vldQ(vldQ), .glbQ(glbQ)
);

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
  localparam int D  = 8;
  localparam int VW = 12;
  localparam int OW = 4;
  localparam int PW = 10;
  localparam int AW = 4;
  localparam int MW = 4;
  localparam int SW = $clog2(D);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [VW-1:0] lkVpn = '0;
  logic [AW-1:0] lkAsn = '0;
  logic lkHit, lkGlobal, lkTrapRd, lkTrapWr;
  logic [SW-1:0] lkSlot;
  logic [PW-1:0] lkPfn;
  logic [AW-1:0] lkAsnOut;
  logic [MW-1:0] lkRdMask, lkWrMask;
  logic insValid = 0, insGlobal = 0, insTrapRd = 0, insTrapWr = 0;
  logic [VW+OW-1:0] insVa = '0;
  logic [PW-1:0] insPfn = '0;
  logic [AW-1:0] insAsn = '0;
  logic [MW-1:0] insRdMask = '0, insWrMask = '0;
  logic cmdFlushAll = 0, cmdFlushProc = 0, cmdFlushAddr = 0;
  logic [VW-1:0] flVpn = '0;
  logic [AW-1:0] flAsn = '0;

  xlat_buffer #(.DEPTH(D), .VPN_W(VW), .OFS_W(OW), .PFN_W(PW), .ASN_W(AW), .MODE_N(MW))
  i_xlat_buffer (
    .clk(clk), .rstN(rstN), .lkVpn(lkVpn), .lkAsn(lkAsn), .lkHit(lkHit), .lkSlot(lkSlot),
    .lkPfn(lkPfn), .lkAsnOut(lkAsnOut), .lkGlobal(lkGlobal), .lkRdMask(lkRdMask),
    .lkWrMask(lkWrMask), .lkTrapRd(lkTrapRd), .lkTrapWr(lkTrapWr),
    .insValid(insValid), .insVa(insVa), .insPfn(insPfn), .insAsn(insAsn),
    .insGlobal(insGlobal), .insRdMask(insRdMask), .insWrMask(insWrMask),
    .insTrapRd(insTrapRd), .insTrapWr(insTrapWr), .cmdFlushAll(cmdFlushAll),
    .cmdFlushProc(cmdFlushProc), .cmdFlushAddr(cmdFlushAddr), .flVpn(flVpn), .flAsn(flAsn)
  );

  // reference model
  bit            mV[D];
  bit            mG[D];
  logic [VW-1:0] mTag[D];
  logic [AW-1:0] mAsn[D];
  logic [PW-1:0] mPfn[D];
  int            mPtr = 0;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishUp();
  end

  // entry side fields are derived from the frame number so one value checks them all
  function automatic logic [SW+PW+AW+2*MW+4-1:0] expLook(logic [VW-1:0] v, logic [AW-1:0] a);
    for (int i = 0; i < D; i++) begin
      if (mV[i] && mTag[i] == v && (mG[i] || mAsn[i] == a))
        return {1'b1, SW'(i), mPfn[i], mAsn[i], mG[i], mPfn[i][3:0], mPfn[i][7:4],
                mPfn[i][8], mPfn[i][9]};
    end
    return '0;
  endfunction

  task automatic probe(input logic [VW-1:0] v, input logic [AW-1:0] a, input string req);
    logic [SW+PW+AW+2*MW+4-1:0] got, exp;
    lkVpn = v;
    lkAsn = a;
    #1;
    exp = expLook(v, a);
    got = {lkHit, lkSlot, lkPfn, lkAsnOut, lkGlobal, lkRdMask, lkWrMask, lkTrapRd, lkTrapWr};
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: vpn=%0h asn=%0h actual=%h expected=%h", req, v, a, got, exp);
    end
  endtask

  task automatic cyc(input bit ins, input logic [VW-1:0] v, input logic [AW-1:0] a,
                     input bit g, input logic [PW-1:0] p,
                     input bit fa, input bit fp, input bit fd,
                     input logic [VW-1:0] fv, input logic [AW-1:0] fs);
    insValid = ins; insVa = {v, OW'($urandom)}; insAsn = a; insGlobal = g; insPfn = p;
    insRdMask = p[3:0]; insWrMask = p[7:4]; insTrapRd = p[8]; insTrapWr = p[9];
    cmdFlushAll = fa; cmdFlushProc = fp; cmdFlushAddr = fd; flVpn = fv; flAsn = fs;
    @(posedge clk);
    for (int i = 0; i < D; i++) begin
      if (fa || (fp && !mG[i]) || (fd && mTag[i] == fv && (mG[i] || mAsn[i] == fs)))
        mV[i] = 0;
    end
    if (fa) mPtr = 0;
    if (ins) begin
      mV[mPtr] = 1; mG[mPtr] = g; mTag[mPtr] = v; mAsn[mPtr] = a; mPfn[mPtr] = p;
      mPtr = (mPtr + 1) % D;
    end
    @(negedge clk);
    insValid = 0; cmdFlushAll = 0; cmdFlushProc = 0; cmdFlushAddr = 0;
  endtask

  task automatic insert(input logic [VW-1:0] v, input logic [AW-1:0] a, input bit g,
                        input logic [PW-1:0] p);
    cyc(1, v, a, g, p, 0, 0, 0, '0, '0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < D; i++) begin
      mV[i] = 0; mG[i] = 0; mTag[i] = '0; mAsn[i] = '0; mPfn[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R9 reset state
    probe(12'h005, 4'h0, "R9");
    probe(12'h000, 4'h0, "R9");

    // fill past the depth: R3 and R4
    for (int i = 0; i <= D; i++) insert(12'h100 + 12'(i), 4'h1, 0, 10'(16'h0A5 + 16'(i) * 37));
    probe(12'h100, 4'h1, "R4");
    probe(12'h100 + 12'(D), 4'h1, "R4");
    probe(12'h101, 4'h1, "R3");
    probe(12'h101, 4'h2, "R1");

    // invalidate-all together with insert: R8, then pointer at slot 1: R5
    cyc(1, 12'h200, 4'h7, 1, 10'h3C3, 1, 0, 0, '0, '0);
    probe(12'h200, 4'h3, "R8");
    probe(12'h102, 4'h1, "R5");
    insert(12'h201, 4'h0, 0, 10'h111);
    probe(12'h201, 4'h0, "R5");

    // duplicates: R2 and shared rule R1
    insert(12'h300, 4'h2, 0, 10'h2F0);
    insert(12'h300, 4'h6, 1, 10'h10F);
    probe(12'h300, 4'h2, "R2");
    probe(12'h300, 4'h5, "R1");

    // R6
    cyc(0, '0, '0, 0, '0, 0, 1, 0, '0, '0);
    probe(12'h300, 4'h2, "R6");
    probe(12'h201, 4'h0, "R6");
    probe(12'h200, 4'h1, "R6");

    // R7: shared slot matches under any identifier
    cyc(0, '0, '0, 0, '0, 0, 0, 1, 12'h300, 4'h9);
    probe(12'h300, 4'h9, "R7");
    probe(12'h200, 4'h9, "R7");

    // R8: invalidate-address and insert of the same page together
    cyc(1, 12'h200, 4'h4, 0, 10'h0FF, 0, 0, 1, 12'h200, 4'h4);
    probe(12'h200, 4'h4, "R8");

    // random mix over a small pool
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 60, 12'($urandom_range(0, 7)), 4'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
          10'($urandom), r >= 97, (r >= 90 && r < 94) || r == 99, r >= 60 && r < 80,
          12'($urandom_range(0, 7)), 4'($urandom_range(0, 3)));
      probe(12'($urandom_range(0, 7)), 4'($urandom_range(0, 3)), "R10");
      probe(12'($urandom_range(0, 7)), 4'($urandom_range(0, 3)), "R2");
    end
    finishUp();
  end
endmodule